// File: doc/BRIEF.md
# Modem Detect Status and Interrupt Unit

This unit collects the status flags from a modem's receive-side detectors and tells the control processor when one of them changes. Four detectors arrive as digital levels. They report carrier present, call-progress tone, answer tone and weak received signal (long loop). A fifth flag is produced inside the unit. It is a timed unscrambled-mark detector that watches the demodulated bit stream before it is descrambled, and sets once the line has stayed at 1 for 166 ms ticks.

All five flags appear in one read-only status byte. A level change in any flag except long loop raises the active-low interrupt, provided interrupts are enabled. The interrupt stays asserted until the processor reads the status byte or the unit is reset. A flag change that lands in the same cycle as the read is kept pending, so it is not lost.

Top module: `det_flag_irq`

## Requirements
- R1: After a strobed 1 bit, status bit 4 (unscrambled mark) becomes 1 once MARK_TICKS (default 166) millisecond ticks have been seen with no strobed 0 bit. After MARK_TICKS-1 ticks it is still 0.
- R2: A strobed 0 bit clears the mark timer and bit 4 at once. Counting starts again from zero at the next strobed 1 bit.
- R3: Status byte layout: bit 0 carrier, bit 1 call progress, bit 2 answer tone, bit 3 long loop, bit 4 unscrambled mark, bits 7:5 always 0. A detector input change shows in the byte on the third rising clock edge after it is applied.
- R4: With the enable set, a change in bit 0, 1, 2 or 4 drives irq_n low on the same edge that updates the status byte.
- R5: A change in bit 3 (long loop) alone never drives irq_n low.
- R6: With the enable clear, irq_n stays high. Changes that occur while the enable is clear are not remembered after the enable is set.
- R7: A one-cycle rd_stb clears a pending interrupt, so irq_n is high after that edge.
- R8: If a flag change and rd_stb meet at the same clock edge, the interrupt stays pending and irq_n remains low after the read.
- R9: Synchronous reset clears the status byte to 0, clears the mark timer and sets irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_in | input | 4 | Detector levels: carrier, call progress, answer tone, long loop |
| rx_bit | input | 1 | Demodulated bit taken before the descrambler |
| rx_bit_stb | input | 1 | One-cycle strobe marking a valid rx_bit |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | One-cycle status read strobe |
| rd_data | output | 8 | Status byte |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A status read and a fresh flag change can meet at one clock edge, so the clear and the set of the pending interrupt compete. The bench first makes sure an interrupt is already pending. It then changes the call-progress input and counts two edges through the synchronizer, so that rd_stb is high exactly on the edge where the change reaches the status byte. The check passes if irq_n is still low after that read and goes high only after a second read with no change.

// File: rtl/det_pkg.sv
`timescale 1ns/1ps
// Shared constants for the detect status unit: flag positions in the
// status byte and the mask of flags that are allowed to interrupt.
package det_pkg;
    localparam int NUM_DET    = 4;   // external detector inputs
    localparam int STAT_W     = 8;   // status byte width
    localparam int BIT_CARR   = 0;
    localparam int BIT_CPRG   = 1;
    localparam int BIT_ANST   = 2;
    localparam int BIT_LLOOP  = 3;
    localparam int BIT_MARK   = 4;
    localparam logic [STAT_W-1:0] IRQ_MASK =
        STAT_W'((1 << BIT_CARR) | (1 << BIT_CPRG) | (1 << BIT_ANST) | (1 << BIT_MARK));
    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/det_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer bank, one chain per bit.
// Assumes each input is a level that stays put for several clock cycles.
module det_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic s1_q, s2_q;
            // Two register stages per asynchronous detector level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= d[i];
                    s2_q <= s1_q;
                end
            end
            assign q[i] = s2_q;
        end
    endgenerate
endmodule

// File: rtl/mark_timer.sv
`timescale 1ns/1ps
// Unscrambled-mark timer. It counts millisecond ticks while the last strobed
// demodulated bit was 1, and saturates at MARK_TICKS. A strobed 0 clears it.
// Assumes rx_bit_stb and ms_tick are single-cycle pulses in the clk domain.
module mark_timer #(
    parameter int MARK_TICKS = 166
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_bit_stb,
    input  logic ms_tick,
    output logic mark
);
    localparam int CNT_W = $clog2(MARK_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MARK_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             line_hi_q;

    // Track the line level and advance the saturating tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            line_hi_q <= 1'b0;
        end else if (rx_bit_stb) begin
            line_hi_q <= rx_bit;
            if (!rx_bit) cnt_q <= '0;
        end else if (ms_tick && line_hi_q && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mark = (cnt_q == CNT_MAX);

    AST_ZERO_CLEARS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bit_stb && !rx_bit) |=> !mark); // R2
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R1
    AST_NO_COUNT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_hi_q && !rx_bit_stb) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/irq_ctl.sv
`timescale 1ns/1ps
// Interrupt pending flag. An enabled event sets it and a read clears it.
// When both meet at one edge, the event wins, so no change is lost.
// The output is also gated by the enable.
module irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic irq_en,
    input  logic rd_stb,
    output logic irq_n
);
    logic pend_q;

    // Set on an enabled event, else clear on read, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (evt && irq_en)    pend_q <= 1'b1;
        else if (rd_stb)           pend_q <= 1'b0;
    end

    assign irq_n = ~(pend_q & irq_en);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(evt && irq_en)) |=> irq_n); // R7
    AST_EVENT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq_en && $stable(irq_en)) |=> !irq_n); // R4
    AST_READ_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq_en && rd_stb) |=> (!irq_n || !irq_en)); // R8
endmodule

// File: rtl/det_flag_irq.sv
`timescale 1ns/1ps
// Detect status byte and interrupt unit. It synchronizes the detector
// levels and appends the unscrambled-mark flag. It registers the byte for
// reading and sends changes in interrupting flags to the interrupt logic.
// Assumes rd_stb is a single-cycle pulse per processor read.
module det_flag_irq #(
    parameter int MARK_TICKS = 166
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [det_pkg::NUM_DET-1:0]   det_in,
    input  logic                          rx_bit,
    input  logic                          rx_bit_stb,
    input  logic                          ms_tick,
    input  logic                          irq_en,
    input  logic                          rd_stb,
    output logic [det_pkg::STAT_W-1:0]    rd_data,
    output logic                          irq_n
);
    import det_pkg::*;

    logic [NUM_DET-1:0] det_s;
    logic               mark;
    stat_t              cur, stat_q, diff;
    logic               evt;

    det_sync #(.W(NUM_DET)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(det_in), .q(det_s)
    );

    mark_timer #(.MARK_TICKS(MARK_TICKS)) i_mark (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
        .rx_bit_stb(rx_bit_stb), .ms_tick(ms_tick), .mark(mark)
    );

    // Assemble the live flag vector in status-byte order
    always_comb begin
        cur             = '0;
        cur[NUM_DET-1:0] = det_s;
        cur[BIT_MARK]   = mark;
    end

    // Status byte register, updated every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= cur;
    end

    assign diff    = cur ^ stat_q;
    assign evt     = |(diff & IRQ_MASK);
    assign rd_data = stat_q;

    irq_ctl i_irq (
        .clk(clk), .rst_n(rst_n), .evt(evt), .irq_en(irq_en),
        .rd_stb(rd_stb), .irq_n(irq_n)
    );

    AST_MASKED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n); // R6
    AST_LLOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && (diff == stat_t'(1 << BIT_LLOOP))) |=> irq_n); // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_W-1:BIT_MARK+1] == '0); // R3
endmodule

// File: tb/test_det_flag_irq.sv
`timescale 1ns/1ps
module test_det_flag_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] det_in = '0;
    logic       rx_bit = 1'b0, rx_bit_stb = 1'b0, ms_tick = 1'b0;
    logic       irq_en = 1'b0, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic       irq;
        logic [7:0] data;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    det_flag_irq i_det_flag_irq (
        .clk(clk), .rst_n(rst_n), .det_in(det_in), .rx_bit(rx_bit),
        .rx_bit_stb(rx_bit_stb), .ms_tick(ms_tick), .irq_en(irq_en),
        .rd_stb(rd_stb), .rd_data(rd_data), .irq_n(irq_n)
    );

    // Driver side: push an expectation, called right after a falling edge
    task automatic expect_now(input string tag, input logic irq, input logic [7:0] data);
        exp_t e;
        e.tag = tag; e.irq = irq; e.data = data;
        sb_q.push_back(e);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read();
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic strobe_bit(input logic v);
        rx_bit = v; rx_bit_stb = 1'b1; @(negedge clk); rx_bit_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0; @(negedge clk);
        end
    endtask

    // Monitor: compare queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk); #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (irq_n !== e.irq || rd_data !== e.data) begin
                    errors++;
                    $display("FAIL %s: irq_n=%b data=%h expected irq_n=%b data=%h",
                             e.tag, irq_n, rd_data, e.irq, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        expect_now("R9 reset state", 1'b1, 8'h00);
        rst_n = 1'b1; irq_en = 1'b1;
        cycles(1);
        // R3 latency and R4 carrier interrupt
        det_in = 4'b0001;
        cycles(2);
        expect_now("R3 not yet visible", 1'b1, 8'h00);
        cycles(1);
        expect_now("R4 carrier raises irq", 1'b0, 8'h01);
        do_read();
        expect_now("R7 read clears irq", 1'b1, 8'h01);
        // R5 long loop is silent
        det_in = 4'b1001;
        cycles(4);
        expect_now("R5 long loop no irq", 1'b1, 8'h09);
        // Answer tone interrupts
        det_in = 4'b1101;
        cycles(4);
        expect_now("R4 answer tone irq", 1'b0, 8'h0D);
        // R8 read meets a call-progress change; irq already pending
        det_in = 4'b1111;
        cycles(2);
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
        expect_now("R8 change with read keeps irq", 1'b0, 8'h0F);
        do_read();
        expect_now("R7 plain read clears", 1'b1, 8'h0F);
        // R6 masked changes are not remembered
        irq_en = 1'b0;
        det_in = 4'b0110;
        cycles(4);
        expect_now("R6 masked irq high", 1'b1, 8'h06);
        irq_en = 1'b1;
        cycles(1);
        expect_now("R6 no memory after enable", 1'b1, 8'h06);
        // R1 mark timer threshold
        strobe_bit(1'b1);
        ticks(165);
        cycles(2);
        expect_now("R1 below threshold", 1'b1, 8'h06);
        ticks(1);
        cycles(2);
        expect_now("R1 mark set and irq", 1'b0, 8'h16);
        do_read();
        // R2 zero bit clears
        strobe_bit(1'b0);
        cycles(2);
        expect_now("R2 zero clears mark", 1'b0, 8'h06);
        do_read();
        // R2 restart from zero after interruption
        strobe_bit(1'b1);
        ticks(100);
        strobe_bit(1'b0);
        strobe_bit(1'b1);
        ticks(100);
        cycles(2);
        expect_now("R2 count restarted", 1'b1, 8'h06);
        // R9 reset mid-run
        rst_n = 1'b0;
        cycles(1);
        expect_now("R9 reset clears byte", 1'b1, 8'h00);
        rst_n = 1'b1;
        det_in = 4'b0000;
        cycles(4);
        expect_now("R9 stays clear after reset", 1'b1, 8'h00);
        cycles(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule